// File: doc/BRIEF.md
# Pointer-Indirect Load/Store Unit

This unit carries out one byte-wide load or store whose address comes from a 16-bit pointer. The pointer is held in a pair of general registers. The surrounding core decodes the instruction and raises `start` for one cycle. Along with it the core supplies the pointer select, the addressing mode, the data register number, a 6-bit displacement, the current pointer value read from the register pair, and the store byte. The unit then drives a synchronous data-memory port.

Some modes change the pointer. Post-increment uses the pointer as it stands and then steps it up by one. Pre-decrement steps the pointer down first and uses the result. The base-plus-offset mode reaches a field of a structure and leaves the pointer untouched. When a mode changes the pointer, the unit hands the new 16-bit value back to the register file as a write-back. A load also returns the fetched byte for the destination register. Flags are never touched.

Every operation takes two cycles after the edge that accepts it. In the first cycle the memory strobe is raised. In the second cycle the register write-backs are offered and `done` is high.

Top module: `ptr_ldst_unit`

## Requirements
- R1: While reset is held, and after it is released until a start is accepted, `done`, `mem_we`, `mem_re`, `load_we` and `ptr_we` are all low.
- R2: `ptr_sel` picks the pointer: 00 picks the pair r27:r26, 01 picks r29:r28 and 10 picks r31:r30. `ptr_lo_reg` names the even (low-byte) register of the pair. `ptr_wdata[7:0]` goes to that even register and `ptr_wdata[15:8]` goes to the odd register just above it.
- R3: Mode 00 (plain) accesses memory at the pointer value and leaves `ptr_we` low.
- R4: Mode 01 (post-increment) accesses memory at the pointer value and writes back the pointer plus one. The carry crosses the byte boundary, so 00FF becomes 0100, and FFFF wraps to 0000.
- R5: Mode 10 (pre-decrement) subtracts one first and accesses memory at the new value. The same value is written back to the pointer, so 0000 wraps to FFFF.
- R6: Mode 11 (offset) with pointer 01 or 10 accesses the pointer plus the unsigned `disp_q` (0 to 63), taken modulo 2^16. `ptr_we` stays low. With pointer 00, `disp_q` is ignored: the access goes to the pointer value and `ptr_we` stays low.
- R7: The first cycle after the accepting edge drives `mem_addr` and raises exactly one strobe: `mem_re` for a load or `mem_we` for a store, with `mem_wdata` equal to the store byte. The second cycle raises `done` with both strobes low. Both strobes are never high together.
- R8: In the `done` cycle of a load, `load_we` is high, `load_reg` equals `data_reg` and `load_data` is the byte the memory returned. A store keeps `load_we` low, and the byte is written at the strobe cycle's address.
- R9: A `start` raised while an operation is in flight is ignored. The cycle after `done` shows no strobe and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue an operation (taken only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| ptr_sel | input | 2 | Pointer pair select |
| amode | input | 2 | Addressing mode |
| data_reg | input | 5 | Destination register of a load |
| disp_q | input | 6 | Unsigned displacement for offset mode |
| ptr_value | input | 16 | Current value of the selected pointer pair |
| store_data | input | 8 | Byte to store |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| load_we | output | 1 | Load result write-back enable |
| load_reg | output | 5 | Load result register number |
| load_data | output | 8 | Load result byte |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_lo_reg | output | 5 | Even register of the pointer pair being written |
| ptr_wdata | output | 16 | Updated pointer value |
| done | output | 1 | Operation completes this cycle |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer, a 6-bit displacement and the pointer pairs based at r26. This makes the top displacement of 63 reachable. It also makes both 16-bit wrap points reachable, from FFFF up and from 0000 down, along with the carry from the low byte into the high byte. Random pointer values near the top of the space, combined with offsets, also cause the offset sum to wrap.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'b00,
    AM_POSTINC = 2'b01,
    AM_PREDEC  = 2'b10,
    AM_OFFSET  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_ACCESS = 2'b01,
    PH_FINISH = 2'b10
  } phase_e;

  localparam logic [1:0] SEL_X = 2'b00;

endpackage

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 6
) (
  input  amode_e            amode,
  input  logic [1:0]        ptr_sel,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic [DISP_W-1:0] disp_q,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] next_ptr,
  output logic              ptr_update
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam int unsigned PAD_W = ADDR_W - DISP_W;

  // one step up or down, wrapping at the pointer width
  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                 input logic down);
    step_ptr = down ? (p - ONE) : (p + ONE);
  endfunction

  // base plus zero-extended offset, wrapping at the pointer width
  function automatic logic [ADDR_W-1:0] add_offset(input logic [ADDR_W-1:0] p,
                                                   input logic [DISP_W-1:0] q);
    add_offset = p + {{PAD_W{1'b0}}, q};
  endfunction

  logic offset_allowed;
  assign offset_allowed = (ptr_sel != SEL_X);

  always_comb begin
    eff_addr   = ptr_value;
    next_ptr   = ptr_value;
    ptr_update = 1'b0;
    case (amode)
      AM_POSTINC: begin
        next_ptr   = step_ptr(ptr_value, 1'b0);
        ptr_update = 1'b1;
      end
      AM_PREDEC: begin
        next_ptr   = step_ptr(ptr_value, 1'b1);
        eff_addr   = next_ptr;
        ptr_update = 1'b1;
      end
      AM_OFFSET: begin
        if (offset_allowed) eff_addr = add_offset(ptr_value, disp_q);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ptr_phase_seq.sv
module ptr_phase_seq
  import ptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic in_access,
  output logic in_finish
);

  phase_e ph_q, ph_d;

  assign accept    = start && (ph_q == PH_IDLE);
  assign in_access = (ph_q == PH_ACCESS);
  assign in_finish = (ph_q == PH_FINISH);

  always_comb begin
    case (ph_q)
      PH_IDLE:   ph_d = accept ? PH_ACCESS : PH_IDLE;
      PH_ACCESS: ph_d = PH_FINISH;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  AST_ACCEPT_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> in_access); // R7
  AST_ACCESS_TO_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    in_access |=> in_finish); // R7
  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_finish |=> (!in_access && !in_finish)); // R9

endmodule

// File: rtl/ptr_ldst_unit.sv
module ptr_ldst_unit
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DISP_W   = 6,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned PTR_BASE = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  logic [1:0]        ptr_sel,
  input  logic [1:0]        amode,
  input  logic [REG_AW-1:0] data_reg,
  input  logic [DISP_W-1:0] disp_q,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic [DATA_W-1:0] store_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              load_we,
  output logic [REG_AW-1:0] load_reg,
  output logic [DATA_W-1:0] load_data,
  output logic              ptr_we,
  output logic [REG_AW-1:0] ptr_lo_reg,
  output logic [ADDR_W-1:0] ptr_wdata,
  output logic              done
);

  localparam logic [REG_AW-1:0] BASE_REG = REG_AW'(PTR_BASE);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  // even register of a pair: base plus twice the select
  function automatic logic [REG_AW-1:0] pair_low(input logic [1:0] sel);
    pair_low = BASE_REG + REG_AW'({sel, 1'b0});
  endfunction

  logic              accept, in_access, in_finish;
  logic [ADDR_W-1:0] ea_w, np_w;
  logic              upd_w;

  logic [ADDR_W-1:0] ea_q, np_q;
  logic              upd_q, st_q;
  logic [REG_AW-1:0] reg_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] wd_q;

  ptr_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .in_access (in_access),
    .in_finish (in_finish)
  );

  ptr_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .amode      (amode_e'(amode)),
    .ptr_sel    (ptr_sel),
    .ptr_value  (ptr_value),
    .disp_q     (disp_q),
    .eff_addr   (ea_w),
    .next_ptr   (np_w),
    .ptr_update (upd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      np_q  <= '0;
      upd_q <= 1'b0;
      st_q  <= 1'b0;
      reg_q <= '0;
      sel_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      ea_q  <= ea_w;
      np_q  <= np_w;
      upd_q <= upd_w;
      st_q  <= op_store;
      reg_q <= data_reg;
      sel_q <= ptr_sel;
      wd_q  <= store_data;
    end
  end

  // first cycle: memory strobe
  assign mem_addr  = ea_q;
  assign mem_wdata = wd_q;
  assign mem_we    = in_access && st_q;
  assign mem_re    = in_access && !st_q;

  // second cycle: write-backs and completion
  assign done       = in_finish;
  assign load_we    = in_finish && !st_q;
  assign load_reg   = reg_q;
  assign load_data  = mem_rdata;
  assign ptr_we     = in_finish && upd_q;
  assign ptr_lo_reg = pair_low(sel_q);
  assign ptr_wdata  = np_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7
  AST_STROBE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> done); // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we || mem_re)); // R7
  AST_STORE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !load_we); // R8
  // post-increment writes address+1, pre-decrement writes the address itself (R4)
  AST_PTR_NEAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> ((ptr_wdata == mem_addr + ONE) || (ptr_wdata == mem_addr))); // R5
  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> !ptr_lo_reg[0]); // R2

endmodule

// File: tb/tb_ptr_ldst_unit.sv
module tb_ptr_ldst_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_store = 1'b0;
  logic [1:0]  ptr_sel = '0, amode = '0;
  logic [4:0]  data_reg = '0;
  logic [5:0]  disp_q = '0;
  logic [15:0] ptr_value = '0;
  logic [7:0]  store_data = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, ptr_wdata;
  logic [7:0]  mem_wdata, load_data;
  logic        mem_we, mem_re, load_we, ptr_we, done;
  logic [4:0]  load_reg, ptr_lo_reg;

  logic [7:0]  rf [32];
  logic [7:0]  mem [MEM_N];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_ldst_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
    .ptr_sel(ptr_sel), .amode(amode), .data_reg(data_reg), .disp_q(disp_q),
    .ptr_value(ptr_value), .store_data(store_data), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .load_we(load_we), .load_reg(load_reg), .load_data(load_data),
    .ptr_we(ptr_we), .ptr_lo_reg(ptr_lo_reg), .ptr_wdata(ptr_wdata), .done(done)
  );

  // synchronous memory model, aliased on the low address bits
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 8'((i * 37 + 11) ^ (i >> 2));
      mem_rdata <= '0;
    end else begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int pair_of(input int sel);
    return 26 + 2 * sel;
  endfunction

  function automatic logic [15:0] want_addr(input int sel, input int md,
                                            input logic [15:0] p, input int q);
    int a = int'(p);
    if (md == 2) a = a + 65535;
    else if (md == 3 && sel != 0) a = a + q;
    return 16'(a % 65536);
  endfunction

  function automatic logic [15:0] want_ptr(input int md, input logic [15:0] p);
    if (md == 1) return 16'((int'(p) + 1) % 65536);
    if (md == 2) return 16'((int'(p) + 65535) % 65536);
    return p;
  endfunction

  task automatic set_ptr(input int sel, input logic [15:0] v);
    rf[pair_of(sel)]     = v[7:0];
    rf[pair_of(sel) + 1] = v[15:8];
  endtask

  task automatic do_op(input bit st, input int sel, input int md, input int rg,
                       input int q, input bit poke);
    int          base = pair_of(sel);
    logic [15:0] p    = {rf[base + 1], rf[base]};
    logic [15:0] ea   = want_addr(sel, md, p, q);
    logic [15:0] np   = want_ptr(md, p);
    bit          upd  = (md == 1 || md == 2);
    logic [7:0]  sd   = rf[rg];
    logic [7:0]  rd;
    @(negedge clk);
    start = 1'b1; op_store = st; ptr_sel = 2'(sel); amode = 2'(md);
    data_reg = 5'(rg); disp_q = 6'(q); ptr_value = p; store_data = sd;
    rd = mem[ea[9:0]];
    @(negedge clk);
    if (poke) begin
      start = 1'b1; op_store = ~st; amode = 2'(md + 1); ptr_value = ~p;
    end else start = 1'b0;
    chk(mem_addr == ea, (md == 0) ? "R3 addr" : (md == 1) ? "R4 addr" :
        (md == 2) ? "R5 addr" : "R6 addr", mem_addr, ea);
    chk(mem_we == st && mem_re == !st && !done, "R7 strobe",
        {mem_we, mem_re, done}, {st, !st, 1'b0});
    if (st) chk(mem_wdata == sd, "R7 wdata", 16'(mem_wdata), 16'(sd));
    @(negedge clk);
    start = 1'b0;
    chk(done && !mem_we && !mem_re, "R7 done", {done, mem_we, mem_re}, 16'b100);
    chk(ptr_we == upd, upd ? "R4 ptr_we" : "R6 ptr_we", 16'(ptr_we), 16'(upd));
    if (upd) begin
      chk(ptr_wdata == np, (md == 1) ? "R4 ptr" : "R5 ptr", ptr_wdata, np);
      chk(ptr_lo_reg == 5'(base), "R2 pair", 16'(ptr_lo_reg), 16'(base));
    end
    chk(load_we == !st, "R8 load_we", 16'(load_we), 16'(!st));
    if (!st) begin
      chk(load_reg == 5'(rg) && load_data == rd, "R8 load",
          {3'b0, load_reg, load_data}, {3'b0, 5'(rg), rd});
      rf[rg] = rd;
    end else begin
      chk(mem[ea[9:0]] == sd, "R8 store", 16'(mem[ea[9:0]]), 16'(sd));
    end
    if (upd) begin
      rf[base]     = ptr_wdata[7:0];
      rf[base + 1] = ptr_wdata[15:8];
    end
    if (poke) begin
      @(negedge clk);
      chk(!done && !mem_we && !mem_re, "R9 ignored", {done, mem_we, mem_re}, 16'b0);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    report();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 5 + 1);
    repeat (3) @(negedge clk);
    chk(!done && !mem_we && !mem_re && !load_we && !ptr_we, "R1 in reset",
        {done, mem_we, mem_re, load_we, ptr_we}, 16'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !mem_we && !mem_re && !load_we && !ptr_we, "R1 after reset",
        {done, mem_we, mem_re, load_we, ptr_we}, 16'b0);

    // Z walks: post-increment from 0060, plain, pre-decrement from 0063
    set_ptr(2, 16'h0060); do_op(0, 2, 1, 0, 0, 0);
    chk({rf[31], rf[30]} == 16'h0061, "R4 Z 0061", {rf[31], rf[30]}, 16'h0061);
    do_op(0, 2, 0, 1, 0, 0);
    set_ptr(2, 16'h0063); do_op(0, 2, 2, 3, 0, 0);
    // offsets: top range with wrap, zero offset, X ignores offset
    set_ptr(1, 16'hFFF0); do_op(0, 1, 3, 4, 63, 0);
    do_op(1, 2, 3, 5, 0, 0);
    set_ptr(0, 16'h0200); do_op(0, 0, 3, 6, 5, 0);
    // carry and wrap of the pointer pair
    set_ptr(0, 16'h00FF); do_op(0, 0, 1, 7, 0, 0);
    set_ptr(0, 16'hFFFF); do_op(1, 0, 1, 8, 0, 0);
    set_ptr(1, 16'h0000); do_op(0, 1, 2, 9, 0, 0);
    set_ptr(1, 16'h0100); do_op(1, 1, 2, 10, 0, 0);
    // store then read back through the opposite step
    rf[11] = 8'hA5; set_ptr(1, 16'h0140); do_op(1, 1, 1, 11, 0, 0);
    do_op(0, 1, 2, 12, 0, 0);
    chk(rf[12] == 8'hA5, "R8 readback", 16'(rf[12]), 16'h00A5);
    // start while busy
    do_op(0, 2, 1, 13, 0, 1);
    do_op(1, 1, 3, 14, 17, 1);

    for (int n = 0; n < 400; n++) begin
      int sel = int'($urandom_range(0, 2));
      int md  = int'($urandom_range(0, 3));
      int rg  = int'($urandom_range(0, 25));
      int q   = int'($urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0)
        set_ptr(sel, ($urandom_range(0, 1) == 1) ? 16'(16'hFFC0 + $urandom_range(0, 63))
                                                 : 16'($urandom_range(0, 40)));
      do_op(1'($urandom_range(0, 1)), sel, md, rg, q, $urandom_range(0, 9) == 0);
    end
    repeat (2) @(negedge clk);
    report();
  end

endmodule